// File: doc/BRIEF.md
# Digit-Serial Binary Field Multiplier

This block multiplies two elements of the binary extension field GF(2^M) held in polynomial basis and returns their product reduced modulo a polynomial supplied at run time. It is meant to sit at the core of an elliptic-curve point datapath, where a sequencer feeds it operands and collects results. The field size M (163 by default) and the digit size D (8 by default) are elaboration parameters; D trades multiplier area against latency.

A single-cycle start strobe latches both operands and the reduction polynomial. The multiplier operand B is then consumed D bits per clock, lowest digit first. Each step adds the digit times A into an unreduced accumulator, and multiplies A by x^D modulo the field polynomial. After ceil(M/D) steps, one extra cycle folds the accumulator down to M bits. The result appears on `product` together with a one-cycle `done` pulse and stays there until the next completion.

The polynomial is passed as its M low coefficients with the x^M term implied. Any trinomial or pentanomial, or any other polynomial of degree M, is handled by the same logic, so the block serves every standard binary field of a given size.

Top module: `gf2m_digit_mul`

## Requirements
- R1: While reset is asserted and after it is released, `busy` and `done` are 0 and `product` is all zeros.
- R2: A completed operation leaves on `product` the value A*B mod f(x). Bit k of `a_in`, `b_in` and `product` is the coefficient of x^k. Bit k of `poly_in` is the coefficient of x^k in f(x), and the x^M term is implied.
- R3: A `start` sampled high while `busy` is low is accepted. The operands and the polynomial are captured at that clock edge, and `busy` is high from the next cycle.
- R4: After an accepted start, `busy` stays high for exactly ceil(M/D)+1 cycles. `done` is high for one cycle, in the first cycle where `busy` is low again.
- R5: A `start` sampled while `busy` is high is ignored. So are changes on `a_in`, `b_in` and `poly_in` after the accepting edge. The result and the timing are those of the accepted operation.
- R6: `product` changes only in a cycle where `done` is high, and holds its value between completions.
- R7: Trinomial and pentanomial polynomials, and all-ones operands, give correct results. This includes a digit size that does not divide M, where the last digit is partly padding.
- R8: A zero operand gives a zero product. An operand equal to 1 returns the other operand unchanged.
- R9: Any D from 1 to M gives the same products, with only the latency changing. A D outside that range, or M below 2, stops elaboration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Start strobe, accepted when not busy |
| a_in | input | M | Multiplicand field element |
| b_in | input | M | Multiplier field element, consumed D bits per cycle |
| poly_in | input | M | Low M coefficients of the reduction polynomial |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| product | output | M | Reduced product, held until the next completion |

## Verification
The bench drives operand values that sit at the edges of the field: zero, one, all ones, and products whose accumulator reaches degree M+D-2. A design that dropped the final fold, or folded its top bits in the wrong order, would leave high-degree terms unreduced and differ from the bit-serial reference. A second instance with D=64 makes the last digit only partly filled with real bits, so a design that consumed one digit too few or too many would return a wrong product, or raise `done` a cycle early or late. Restarts while busy, and operand and polynomial inputs that change after acceptance, are aimed at designs that fail to latch their inputs: such a design would corrupt the result or stretch the busy window.

// File: rtl/gf2m_mul_pkg.sv
package gf2m_mul_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_STEP = 2'd1,
      ST_FOLD = 2'd2
   } mul_state_e;

   function automatic int ceil_div(input int n, input int d);
      return (n + d - 1) / d;
   endfunction

   function automatic int cnt_bits(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/gf2m_digit_pp.sv
// Carry-less product of an M-bit element with one D-bit digit.
// Result width M+D holds the full unreduced degree M+D-2 product.
module gf2m_digit_pp #(
   parameter int M = 163,
   parameter int D = 8
) (
   input  logic [M-1:0]   a,
   input  logic [D-1:0]   dig,
   output logic [M+D-1:0] pp
);
   localparam int W = M + D;

   logic [W-1:0] acc [D+1];

   assign acc[0] = '0;

   for (genvar j = 0; j < D; j++) begin : g_term
      logic [W-1:0] shifted;
      assign shifted    = W'(a) << j;
      assign acc[j + 1] = acc[j] ^ (dig[j] ? shifted : '0);
   end

   assign pp = acc[D];

endmodule

// File: rtl/gf2m_fold.sv
// Folds the X high coefficients of an (M+X)-bit polynomial back below x^M
// using x^M == low terms of f(x). The scan runs top-down, so a term that
// lands at or above x^M is folded again by a later iteration.
module gf2m_fold #(
   parameter int M = 163,
   parameter int X = 8
) (
   input  logic [M+X-1:0] v,
   input  logic [M-1:0]   poly,
   output logic [M-1:0]   r
);
   logic [M+X-1:0] t;

   always_comb begin
      t = v;
      for (int i = M + X - 1; i >= M; i--) begin
         if (t[i]) begin
            t[i-M +: M] = t[i-M +: M] ^ poly;
            t[i]        = 1'b0;
         end
      end
      r = t[M-1:0];
   end

endmodule

// File: rtl/gf2m_mul_seq.sv
// Sequencer: idle -> NDIG digit steps -> one fold cycle -> idle.
module gf2m_mul_seq
   import gf2m_mul_pkg::*;
#(
   parameter int NDIG = 21
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy,
   output logic done,
   output logic load,
   output logic step,
   output logic fold
);
   localparam int CW = cnt_bits(NDIG);
   localparam logic [CW-1:0] LAST = CW'(NDIG - 1);

   mul_state_e state_q;
   logic [CW-1:0] cnt_q;
   logic          done_q;

   assign load = (state_q == ST_IDLE) && start;
   assign step = (state_q == ST_STEP);
   assign fold = (state_q == ST_FOLD);
   assign busy = (state_q != ST_IDLE);
   assign done = done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (start) begin
                  state_q <= ST_STEP;
                  cnt_q   <= '0;
               end
            end
            ST_STEP: begin
               if (cnt_q == LAST) begin
                  state_q <= ST_FOLD;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            ST_FOLD: begin
               state_q <= ST_IDLE;
               done_q  <= 1'b1;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/gf2m_digit_mul.sv
// Digit-serial GF(2^M) multiplier, lowest digit of B first.
module gf2m_digit_mul
   import gf2m_mul_pkg::*;
#(
   parameter int M = 163,
   parameter int D = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic [M-1:0] a_in,
   input  logic [M-1:0] b_in,
   input  logic [M-1:0] poly_in,
   output logic         busy,
   output logic         done,
   output logic [M-1:0] product
);
   localparam int NDIG = ceil_div(M, D);
   localparam int BW   = NDIG * D;
   localparam int CWID = M + D;

   // elaboration-time parameter checks (R9)
   if (M < 2) begin : g_bad_field
      $error("gf2m_digit_mul: field size M must be at least 2");
   end
   if (D < 1 || D > M) begin : g_bad_digit
      $error("gf2m_digit_mul: digit size D must lie in 1..M");
   end

   logic load, step, fold;

   logic [M-1:0]    a_q;
   logic [BW-1:0]   b_q;
   logic [CWID-1:0] c_q;
   logic [M-1:0]    poly_q;
   logic [M-1:0]    prod_q;

   logic [CWID-1:0] pp;
   logic [M-1:0]    a_next;
   logic [M-1:0]    c_red;

   gf2m_mul_seq #(.NDIG(NDIG)) u_seq (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start),
      .busy  (busy),
      .done  (done),
      .load  (load),
      .step  (step),
      .fold  (fold)
   );

   gf2m_digit_pp #(.M(M), .D(D)) u_pp (
      .a   (a_q),
      .dig (b_q[D-1:0]),
      .pp  (pp)
   );

   // A * x^D mod f: shift then fold the D spilled coefficients
   gf2m_fold #(.M(M), .X(D)) u_fold_a (
      .v    ({a_q, {D{1'b0}}}),
      .poly (poly_q),
      .r    (a_next)
   );

   // final reduction of the unreduced accumulator
   gf2m_fold #(.M(M), .X(D)) u_fold_c (
      .v    (c_q),
      .poly (poly_q),
      .r    (c_red)
   );

   // B shift register: a single-digit field needs no shift
   if (NDIG == 1) begin : g_b_single
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    b_q <= '0;
         else if (load) b_q <= BW'(b_in);
      end
   end else begin : g_b_shift
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    b_q <= '0;
         else if (load) b_q <= BW'(b_in);
         else if (step) b_q <= b_q >> D;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_q    <= '0;
         c_q    <= '0;
         poly_q <= '0;
         prod_q <= '0;
      end else begin
         if (load) begin
            a_q    <= a_in;
            c_q    <= '0;
            poly_q <= poly_in;
         end else if (step) begin
            a_q <= a_next;
            c_q <= c_q ^ pp;
         end
         if (fold) begin
            prod_q <= c_red;
         end
      end
   end

   assign product = prod_q;

endmodule

// File: rtl/gf2m_mul_chk.sv
module gf2m_mul_chk
   import gf2m_mul_pkg::*;
#(
   parameter int M = 163,
   parameter int D = 8
) (
   input logic         clk,
   input logic         rst_n,
   input logic         start,
   input logic         busy,
   input logic         done,
   input logic [M-1:0] product
);
   localparam int NDIG = ceil_div(M, D);
   localparam logic [31:0] BUSY_LEN = 32'(NDIG + 1);

   logic [31:0] busy_cyc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    busy_cyc <= '0;
      else if (busy) busy_cyc <= busy_cyc + 32'd1;
      else           busy_cyc <= '0;
   end

   a_r3_start_takes: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);

   a_r4_latency: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (busy_cyc == BUSY_LEN));

   a_r4_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r4_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   a_r5_no_early_end: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && (busy_cyc < BUSY_LEN - 32'd1)) |=> busy);

   a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(product));

endmodule

bind gf2m_digit_mul gf2m_mul_chk #(.M(M), .D(D)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .start   (start),
   .busy    (busy),
   .done    (done),
   .product (product)
);

// File: tb/tb_gf2m_digit_mul.sv
`timescale 1ns/1ps
module tb_gf2m_digit_mul;
   localparam int M   = 163;
   localparam int D_A = 8;
   localparam int D_B = 64;
   localparam int N_A = (M + D_A - 1) / D_A;
   localparam int N_B = (M + D_B - 1) / D_B;
   localparam int NMAX = (N_A > N_B) ? N_A : N_B;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [M-1:0] a_in = '0, b_in = '0, poly_in = '0;
   logic busy_a, done_a, busy_b, done_b;
   logic [M-1:0] prod_a, prod_b;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   gf2m_digit_mul #(.M(M), .D(D_A)) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .a_in(a_in), .b_in(b_in),
      .poly_in(poly_in), .busy(busy_a), .done(done_a), .product(prod_a));

   gf2m_digit_mul #(.M(M), .D(D_B)) dut_wide (
      .clk(clk), .rst_n(rst_n), .start(start), .a_in(a_in), .b_in(b_in),
      .poly_in(poly_in), .busy(busy_b), .done(done_b), .product(prod_b));

   // bit-serial shift-and-add reference, highest bit of b first
   function automatic logic [M-1:0] ref_mul(input logic [M-1:0] a,
                                            input logic [M-1:0] b,
                                            input logic [M-1:0] p);
      logic [M-1:0] r;
      logic         hi;
      r = '0;
      for (int i = M - 1; i >= 0; i--) begin
         hi = r[M-1];
         r  = r << 1;
         if (hi)   r = r ^ p;
         if (b[i]) r = r ^ a;
      end
      return r;
   endfunction

   function automatic logic [M-1:0] rnd();
      logic [191:0] v;
      for (int k = 0; k < 6; k++) v[k*32 +: 32] = $urandom;
      return v[M-1:0];
   endfunction

   task automatic chk(input bit ok, input string req,
                      input logic [M-1:0] act, input logic [M-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // per-cycle model state
   bit           active = 1'b0;
   int           cyc = 0;
   logic [M-1:0] exp_new = '0;
   logic [M-1:0] exp_old = '0;
   string        cur_lbl = "R2";

   task automatic cmp_dut(input logic bsy, input logic dn, input logic [M-1:0] pr,
                          input int nd, input string lbl);
      bit eb, ed;
      eb = (cyc >= 1) && (cyc <= nd + 1);
      ed = (cyc == nd + 2);
      chk(bsy == eb, (cyc == 1) ? "R3 busy" : "R4 busy", M'(bsy), M'(eb));
      chk(dn == ed, "R4 done", M'(dn), M'(ed));
      if (cyc >= nd + 2) chk(pr == exp_new, lbl, pr, exp_new);
      else               chk(pr == exp_old, "R6 hold", pr, exp_old);
   endtask

   always @(negedge clk) begin
      if (active) begin
         cyc++;
         cmp_dut(busy_a, done_a, prod_a, N_A, cur_lbl);
         cmp_dut(busy_b, done_b, prod_b, N_B, {cur_lbl, " R9 wide"});
      end
   end

   task automatic run_op(input logic [M-1:0] a, input logic [M-1:0] b,
                         input logic [M-1:0] p, input string lbl, input bit poke);
      @(negedge clk);
      a_in = a; b_in = b; poly_in = p; start = 1'b1;
      exp_old = exp_new;
      exp_new = ref_mul(a, b, p);
      cur_lbl = lbl;
      @(posedge clk);
      cyc    = 0;
      active = 1'b1;
      @(negedge clk);
      start = 1'b0;
      a_in = rnd(); b_in = rnd(); poly_in = rnd();   // R5: must be ignored
      if (poke) begin
         @(negedge clk);
         start = 1'b1; a_in = rnd(); b_in = rnd();
         @(negedge clk);
         start = 1'b0;
      end
      wait (cyc >= NMAX + 4);
      active = 1'b0;
   endtask

   localparam logic [M-1:0] PENTA = M'((1 << 7) | (1 << 6) | (1 << 3) | 1);
   localparam logic [M-1:0] TRI   = (M'(1) << 99) | M'(1);

   initial begin
      logic [M-1:0] x, y;
      repeat (3) @(negedge clk);
      chk(!busy_a && !done_a && prod_a == '0, "R1 reset", prod_a, '0);
      chk(!busy_b && !done_b && prod_b == '0, "R1 reset wide", prod_b, '0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy_a && !done_a && prod_a == '0, "R1 after release", prod_a, '0);

      x = rnd();
      run_op('0, x, PENTA, "R8 zero a", 1'b0);
      run_op(x, '0, PENTA, "R8 zero b", 1'b0);
      run_op(M'(1), x, PENTA, "R8 one a", 1'b0);
      run_op(x, M'(1), PENTA, "R8 one b", 1'b0);
      for (int k = 0; k < 6; k++) run_op(rnd(), rnd(), PENTA, "R2 random", 1'b0);
      run_op(M'(1) << (M - 1), M'(1) << (M - 1), PENTA, "R2 top degree", 1'b0);
      for (int k = 0; k < 3; k++) run_op(rnd(), rnd(), TRI, "R7 trinomial", 1'b0);
      run_op('1, '1, PENTA, "R7 all ones", 1'b0);
      run_op('1, '1, TRI, "R7 all ones tri", 1'b0);
      y = rnd();
      run_op(y, rnd(), PENTA, "R5 restart ignored", 1'b1);
      run_op(rnd(), y, rnd(), "R7 random poly", 1'b0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule